// File: doc/BRIEF.md
# Dual-Mode Watchdog Timer

This block is a watchdog counter that advances on machine-cycle ticks and asks for a system reset when software fails to service it in time. The timeout is a power-of-two multiple of a base count, chosen by a 3-bit field in the control register. The default base is 16K ticks, so the timeout runs from 16K to 2048K ticks. Counting pauses whenever the power-down input is high. It can also pause while the idle input is high, if the control register asks for that.

There are two ways to run it. In software mode, an enable bit starts and stops counting. A restart bit clears the counter, and hardware clears that bit again on the next tick. In hardware mode, the watchdog arms when the byte 0x1E and then the byte 0xE1 are written to the restart register. Once armed it stays armed until reset, and only the same two-byte key restarts the counter. On a timeout the block raises its reset request for exactly two clocks and starts counting again from zero. A second output tells the reset network whether the external reset pin should also be driven.

Three state machines do the work. The mode machine has the states M_SOFT, M_HW_WAIT and M_HW_ARMED. A control write with the mode bit set moves M_SOFT to M_HW_WAIT. A control write with the mode bit clear moves M_HW_WAIT back to M_SOFT. A completed key moves M_HW_WAIT to M_HW_ARMED, and M_HW_ARMED is left only by reset. The key machine has the states K_IDLE and K_GOT1E. Writing 0x1E in K_IDLE moves it to K_GOT1E. Any restart write in K_GOT1E returns it to K_IDLE, and the write counts as a key only if the byte is 0xE1. The key machine is forced to K_IDLE while the block is in M_SOFT. The pulse machine has the states P_QUIET, P_ONE and P_TWO. A timeout moves P_QUIET to P_ONE. P_ONE always moves to P_TWO. P_TWO moves back to P_QUIET, or to P_ONE if another timeout happens on that edge.

Top module: `dual_wdog`

## Requirements
- R1: The control register (write with wr_sel_i=0) has these fields: bits [2:0] select the timeout exponent N, bit 3 is the idle hold, bit 4 is the pin-off bit, bit 5 is the mode bit, bit 6 is the restart bit and bit 7 is the enable bit. The control write is captured on edge W. The reset request then rises in the cycle after edge W + 2^(BASE_LOG+N), when a tick is present on every clock.
- R2: The reset request stays high for exactly two clocks. The counter starts again from zero on the timeout edge, so the next request comes 2^(BASE_LOG+N) ticks after the previous one.
- R3: In software mode, clearing bit 7 halts the counter and keeps its value. Setting bit 7 again resumes counting from that value.
- R4: In software mode, writing bit 6 as 1 sets the restart bit. On the next tick the counter is cleared and bit 6 reads back as 0. In hardware mode, bit 6 has no effect on counting and stays set.
- R5: In hardware mode (bit 5 = 1), writing 0x1E and then 0xE1 to the restart register (wr_sel_i=1) arms the watchdog. Arming clears the counter. Once armed, bit 7 reads 1, and control writes cannot clear bit 5 or bit 7.
- R6: If any byte other than 0xE1 follows 0x1E, the key is discarded, and this includes a second 0x1E. In software mode, key writes are ignored.
- R7: While armed, a completed key clears the counter. If the key completes on the same edge that would time out, the clear wins and no request is raised on that edge.
- R8: With bit 3 = 1, counting pauses while idle_i is high. With bit 3 = 0, counting continues while idle_i is high.
- R9: After reset, every control bit reads 0 and nothing counts. Counting also pauses while pdown_i is high or tick_i is low.
- R10: drive_pin_o is high with the reset request only when bit 4 is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | Machine-cycle tick |
| idle_i | input | 1 | System is in idle mode |
| pdown_i | input | 1 | System is in power-down |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 1 | Write target: 0 control, 1 restart |
| wr_data_i | input | 8 | Write data |
| rd_sel_i | input | 1 | Read target: 0 control, 1 restart (reads 0) |
| rd_data_o | output | 8 | Read data |
| rst_req_o | output | 1 | Reset request, two clocks wide |
| drive_pin_o | output | 1 | External reset pin should be driven |

## Verification
The two functions that can fall on the same edge are the counter restart by a completed hardware key and the timeout. The bench arms the watchdog on edge B. It then places the 0x1E write on edge B+3 and the 0xE1 write on edge B+4, which is exactly the edge where a base-4 timeout would fire. The bench then requires the first request to appear only after edge B+8. The same kind of collision between a software restart and ongoing counts is judged by measuring the request edge against the restart write edge plus one plus the timeout.

// File: rtl/wdg_pkg.sv
package wdg_pkg;

    typedef enum logic [1:0] {
        M_SOFT,
        M_HW_WAIT,
        M_HW_ARMED
    } wdg_mode_e;

    typedef enum logic {
        K_IDLE,
        K_GOT1E
    } wdg_key_e;

    typedef enum logic [1:0] {
        P_QUIET,
        P_ONE,
        P_TWO
    } wdg_pulse_e;

    localparam int CB_IDLE = 3;
    localparam int CB_PIN  = 4;
    localparam int CB_HW   = 5;
    localparam int CB_KICK = 6;
    localparam int CB_EN   = 7;

endpackage

// File: rtl/wdg_key.sv
module wdg_key
    import wdg_pkg::*;
#(
    parameter logic [7:0] KEY_A = 8'h1E,
    parameter logic [7:0] KEY_B = 8'hE1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       act_i,
    input  logic       wr_i,
    input  logic [7:0] data_i,
    output logic       ok_o
);

    wdg_key_e st_q, st_d;

    always_comb begin
        st_d = st_q;
        if (!act_i) begin
            st_d = K_IDLE;
        end else if (wr_i) begin
            unique case (st_q)
                K_IDLE:  st_d = (data_i == KEY_A) ? K_GOT1E : K_IDLE;
                K_GOT1E: st_d = K_IDLE;
                default: st_d = K_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= K_IDLE;
        else        st_q <= st_d;
    end

    always_comb begin
        ok_o = act_i && wr_i && (st_q == K_GOT1E) && (data_i == KEY_B);
    end

    // R6: a completed key always leaves the machine waiting for a new first byte
    p_key_rearm_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ok_o |=> (st_q == K_IDLE));

endmodule

// File: rtl/wdg_count.sv
module wdg_count #(
    parameter int BASE_LOG = 14,
    localparam int CW = BASE_LOG + 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cnt_en_i,
    input  logic       clr_i,
    input  logic [2:0] ps_i,
    output logic       fire_o
);

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] last_v;

    always_comb begin
        last_v = (CW'(1) << (BASE_LOG + int'(ps_i))) - CW'(1);
        fire_o = cnt_en_i && !clr_i && (cnt_q >= last_v);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        cnt_q <= '0;
        else if (clr_i)    cnt_q <= '0;
        else if (fire_o)   cnt_q <= '0;
        else if (cnt_en_i) cnt_q <= cnt_q + CW'(1);
    end

    // R4 / R7: a restart leaves the counter at zero
    p_clear_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (cnt_q == '0));

    // R9: without a counted tick the value is frozen
    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!cnt_en_i && !clr_i) |=> $stable(cnt_q));

endmodule

// File: rtl/wdg_pulse.sv
module wdg_pulse
    import wdg_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic fire_i,
    output logic req_o
);

    wdg_pulse_e st_q, st_d;

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            P_QUIET: st_d = fire_i ? P_ONE : P_QUIET;
            P_ONE:   st_d = P_TWO;
            P_TWO:   st_d = fire_i ? P_ONE : P_QUIET;
            default: st_d = P_QUIET;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= P_QUIET;
        else        st_q <= st_d;
    end

    always_comb begin
        req_o = (st_q != P_QUIET);
    end

    // R2: a request that starts lasts for a second clock
    p_width_min_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(req_o) |=> req_o);

    // R2: a request never exceeds two clocks without a new timeout
    p_width_max_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_o && $past(req_o) && !fire_i) |=> !req_o);

endmodule

// File: rtl/dual_wdog.sv
module dual_wdog
    import wdg_pkg::*;
#(
    parameter int         BASE_LOG = 14,
    parameter logic [7:0] KEY_A    = 8'h1E,
    parameter logic [7:0] KEY_B    = 8'hE1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick_i,
    input  logic       idle_i,
    input  logic       pdown_i,
    input  logic       wr_en_i,
    input  logic       wr_sel_i,
    input  logic [7:0] wr_data_i,
    input  logic       rd_sel_i,
    output logic [7:0] rd_data_o,
    output logic       rst_req_o,
    output logic       drive_pin_o
);

    wdg_mode_e  mode_q, mode_d;
    logic [2:0] ps_q;
    logic       idle_hold_q, pin_off_q, en_q, kick_q;
    logic       ctrl_wr, key_wr, key_ok, hw_sel;
    logic       running, cnt_en, clr, fire;

    always_comb begin
        ctrl_wr = wr_en_i && !wr_sel_i;
        key_wr  = wr_en_i && wr_sel_i;
        hw_sel  = (mode_q != M_SOFT);
    end

    always_comb begin
        mode_d = mode_q;
        unique case (mode_q)
            M_SOFT:     if (ctrl_wr && wr_data_i[CB_HW]) mode_d = M_HW_WAIT;
            M_HW_WAIT: begin
                if (key_ok)                            mode_d = M_HW_ARMED;
                else if (ctrl_wr && !wr_data_i[CB_HW]) mode_d = M_SOFT;
            end
            M_HW_ARMED: mode_d = M_HW_ARMED;
            default:    mode_d = M_SOFT;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mode_q <= M_SOFT;
        else        mode_q <= mode_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ps_q        <= '0;
            idle_hold_q <= 1'b0;
            pin_off_q   <= 1'b0;
            en_q        <= 1'b0;
            kick_q      <= 1'b0;
        end else begin
            if (ctrl_wr) begin
                ps_q        <= wr_data_i[2:0];
                idle_hold_q <= wr_data_i[CB_IDLE];
                pin_off_q   <= wr_data_i[CB_PIN];
                if (mode_q == M_SOFT) en_q <= wr_data_i[CB_EN];
            end
            if (ctrl_wr && wr_data_i[CB_KICK])
                kick_q <= 1'b1;
            else if (mode_q == M_SOFT && tick_i && kick_q)
                kick_q <= 1'b0;
        end
    end

    always_comb begin
        running     = (mode_q == M_SOFT) ? en_q : (mode_q == M_HW_ARMED);
        cnt_en      = running && tick_i && !pdown_i && !(idle_i && idle_hold_q);
        clr         = key_ok || ((mode_q == M_SOFT) && kick_q);
        rd_data_o   = rd_sel_i ? 8'h00
                               : {running, kick_q, hw_sel, pin_off_q, idle_hold_q, ps_q};
        drive_pin_o = rst_req_o && !pin_off_q;
    end

    wdg_key #(.KEY_A(KEY_A), .KEY_B(KEY_B)) key_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .act_i  (hw_sel),
        .wr_i   (key_wr),
        .data_i (wr_data_i),
        .ok_o   (key_ok)
    );

    wdg_count #(.BASE_LOG(BASE_LOG)) count_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .cnt_en_i (cnt_en),
        .clr_i    (clr),
        .ps_i     (ps_q),
        .fire_o   (fire)
    );

    wdg_pulse pulse_i (
        .clk   (clk),
        .rst_n (rst_n),
        .fire_i(fire),
        .req_o (rst_req_o)
    );

    // R5: once armed, only reset leaves hardware mode
    p_armed_stays_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == M_HW_ARMED) |=> (mode_q == M_HW_ARMED));

    // R10: the pin flag never appears without a request
    p_pin_needs_req_r10: assert property (@(posedge clk) disable iff (!rst_n)
        drive_pin_o |-> rst_req_o);

    // R6: software mode never reaches the armed state directly
    p_soft_no_arm_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == M_SOFT) |=> (mode_q != M_HW_ARMED));

endmodule

// File: tb/dual_wdog_tb.sv
module dual_wdog_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int BL = 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_i = 1'b1, idle_i = 1'b0, pdown_i = 1'b0;
    logic       wr_en_i = 1'b0, wr_sel_i = 1'b0, rd_sel_i = 1'b0;
    logic [7:0] wr_data_i = 8'h00;
    logic [7:0] rd_data_o;
    logic       rst_req_o, drive_pin_o;

    int cyc = 0;
    int n_cmp = 0;
    int n_bad = 0;
    int wcyc = 0;
    bit done = 1'b0;

    dual_wdog #(.BASE_LOG(BL)) dut_i (
        .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .idle_i(idle_i), .pdown_i(pdown_i),
        .wr_en_i(wr_en_i), .wr_sel_i(wr_sel_i), .wr_data_i(wr_data_i),
        .rd_sel_i(rd_sel_i), .rd_data_o(rd_data_o),
        .rst_req_o(rst_req_o), .drive_pin_o(drive_pin_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input string tag, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0; tick_i = 1'b1; idle_i = 1'b0; pdown_i = 1'b0;
        wr_en_i = 1'b0; rd_sel_i = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic wr(input logic sel, input logic [7:0] d);
        wr_en_i = 1'b1; wr_sel_i = sel; wr_data_i = d;
        @(negedge clk);
        wr_en_i = 1'b0;
        wcyc = cyc;
    endtask

    task automatic rd_ctrl(output int v);
        rd_sel_i = 1'b0;
        #1 v = int'(rd_data_o);
    endtask

    task automatic wait_rise(input int maxc, output int at);
        at = -1;
        for (int i = 0; i < maxc; i++) begin
            if (at < 0 && rst_req_o) at = cyc;
            if (at < 0) @(negedge clk);
        end
    endtask

    task automatic wait_to(input int t);
        while (cyc < t) @(negedge clk);
    endtask

    task automatic arm(output int b);
        wr(1'b0, 8'h20);
        wr(1'b1, 8'h1E);
        wr(1'b1, 8'hE1);
        b = wcyc;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired actual=%0d expected=0", cyc);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        int at, at2, v, w, b, c;
        do_reset();
        // R9: reset state
        rd_ctrl(v);
        chk("R9 ctrl after reset", v, 0);
        chk("R9 req after reset", int'(rst_req_o), 0);
        chk("R10 pin after reset", int'(drive_pin_o), 0);
        wait_rise(20, at);
        chk("R9 no count when disabled", at, -1);

        // R1: sweep over every exponent
        for (int ps = 0; ps < 8; ps++) begin
            do_reset();
            wr(1'b0, 8'h80 | 8'(ps));
            w = wcyc;
            wait_rise(700, at);
            chk($sformatf("R1 timeout ps=%0d", ps), at - w, (1 << (BL + ps)));
            if (ps == 0) begin
                chk("R10 pin driven", int'(drive_pin_o), 1);
                @(negedge clk);
                chk("R2 second clock high", int'(rst_req_o), 1);
                @(negedge clk);
                chk("R2 third clock low", int'(rst_req_o), 0);
                wait_rise(20, at2);
                chk("R2 restart from zero", at2 - at, 4);
            end
        end

        // R10: pin-off bit
        do_reset();
        wr(1'b0, 8'h90);
        wait_rise(20, at);
        chk("R10 req with pin off", int'(rst_req_o), 1);
        chk("R10 pin off", int'(drive_pin_o), 0);

        // R3: halt and resume
        do_reset();
        wr(1'b0, 8'h80);
        w = wcyc;
        wait_to(w + 1);
        wr(1'b0, 8'h00);
        rd_ctrl(v);
        chk("R3 enable cleared", v, 0);
        wait_rise(12, at);
        chk("R3 halted", at, -1);
        wr(1'b0, 8'h80);
        w = wcyc;
        wait_rise(20, at);
        chk("R3 resume keeps count", at - w, 2);

        // R4: software restart bit
        do_reset();
        wr(1'b0, 8'h81);
        w = wcyc;
        wait_to(w + 4);
        wr(1'b0, 8'hC1);
        b = wcyc;
        rd_ctrl(v);
        chk("R4 restart bit set", v, 8'hC1);
        @(negedge clk);
        rd_ctrl(v);
        chk("R4 restart bit self-clears", v, 8'h81);
        wait_rise(30, at);
        chk("R4 counter cleared", at - b, 9);

        // R8: idle hold on and off
        do_reset();
        idle_i = 1'b1;
        wr(1'b0, 8'h88);
        wait_rise(20, at);
        chk("R8 idle hold pauses", at, -1);
        idle_i = 1'b0;
        c = cyc;
        wait_rise(20, at);
        chk("R8 resume after idle", at - c, 4);
        do_reset();
        idle_i = 1'b1;
        wr(1'b0, 8'h80);
        w = wcyc;
        wait_rise(20, at);
        chk("R8 idle without hold counts", at - w, 4);

        // R9: power-down and missing tick
        do_reset();
        pdown_i = 1'b1;
        wr(1'b0, 8'h80);
        wait_rise(20, at);
        chk("R9 power-down pauses", at, -1);
        pdown_i = 1'b0;
        c = cyc;
        wait_rise(20, at);
        chk("R9 resume after power-down", at - c, 4);
        do_reset();
        tick_i = 1'b0;
        wr(1'b0, 8'h80);
        wait_rise(20, at);
        chk("R9 no tick no count", at, -1);
        tick_i = 1'b1;
        c = cyc;
        wait_rise(20, at);
        chk("R9 counts with tick", at - c, 4);

        // R6: key ignored in software mode
        do_reset();
        wr(1'b1, 8'h1E);
        wr(1'b1, 8'hE1);
        rd_ctrl(v);
        chk("R6 soft mode ignores key", v, 0);
        wait_rise(20, at);
        chk("R6 soft mode no arm", at, -1);

        // R6: broken keys
        do_reset();
        wr(1'b0, 8'h20);
        wr(1'b1, 8'h1E);
        wr(1'b1, 8'h00);
        wr(1'b1, 8'hE1);
        rd_ctrl(v);
        chk("R6 foreign byte discards", v, 8'h20);
        wr(1'b1, 8'h1E);
        wr(1'b1, 8'h1E);
        wr(1'b1, 8'hE1);
        rd_ctrl(v);
        chk("R6 double first byte discards", v, 8'h20);
        wait_rise(20, at);
        chk("R6 not armed", at, -1);
        wr(1'b1, 8'h1E);
        wr(1'b1, 8'hE1);
        rd_ctrl(v);
        chk("R6 clean key arms", v, 8'hA0);

        // R5: arming, lock and timeout
        do_reset();
        wr(1'b0, 8'h20);
        rd_ctrl(v);
        chk("R5 hw mode before arming", v, 8'h20);
        wr(1'b1, 8'h1E);
        wr(1'b1, 8'hE1);
        b = wcyc;
        wr(1'b0, 8'h00);
        rd_ctrl(v);
        chk("R5 cannot disable", v, 8'hA0);
        wait_rise(20, at);
        chk("R5 armed timeout", at - b, 4);

        // R4: restart bit inert in hardware mode
        do_reset();
        arm(b);
        wr(1'b0, 8'h40);
        wait_rise(20, at);
        chk("R4 hw restart bit no effect", at - b, 4);
        rd_ctrl(v);
        chk("R4 hw restart bit stays", v, 8'hE0);

        // R7: key restart mid-count
        do_reset();
        arm(b);
        wr(1'b1, 8'h1E);
        wr(1'b1, 8'hE1);
        wait_rise(20, at);
        chk("R7 key restarts counter", at - b, 6);

        // R7: key completes on the timeout edge
        do_reset();
        arm(b);
        wait_to(b + 2);
        wr(1'b1, 8'h1E);
        wr(1'b1, 8'hE1);
        chk("R7 key write edge", wcyc - b, 4);
        wait_rise(20, at);
        chk("R7 key beats timeout", at - b, 8);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule